// File: doc/BRIEF.md
# Registered Eight-Way Selector With Tristate Outputs

This block picks one bit out of eight stored data bits and presents it on a pair of complementary outputs. The eight data inputs are sampled into flip-flops on each rising clock edge. The three-bit select code goes through a level-sensitive latch: while the hold input is low the latch is transparent, and while it is high the latch keeps the last code. The selected stored bit drives a true output and an inverted output.

Three output-enable inputs together decide whether both outputs are driven or left floating. A separate flag reports the driven state so a checker can see it without resolving high-impedance values. A synchronous active-high reset clears the data register. The select latch has no reset, so a user must load it before reading the outputs.

Top module: `octsel_reg`

## Requirements
- R1: On each rising clock edge with reset low, the data register takes the value on `din`. A change on `din` between edges does not change `y` until the next rising edge.
- R2: A rising clock edge with `rst` high clears all stored data bits to 0, so the driven `y` reads 0 for every select code.
- R3: While `sel_hold` is 0, the select latch is transparent. A new code on `sel` reaches `y` in the same cycle, with no clock edge needed.
- R4: While `sel_hold` is 1, the select latch keeps its code. Changes on `sel` do not change `y`.
- R5: The select code maps to stored bits in binary order. Code k selects `din[k]` as captured, so code 0 selects bit 0 and code 7 selects bit 7.
- R6: Whenever the outputs are driven, `y_n` is the logical inverse of `y`.
- R7: The outputs are driven, and `drv_en` is 1, only when `oe_lo_a` is 0, `oe_lo_b` is 0 and `oe_hi` is 1. For all other seven combinations, `drv_en` is 0 and `y` and `y_n` are high impedance.
- R8: The output enables change neither the stored data nor the latched select code. After the outputs are disabled and then re-enabled, `y` shows the same bit as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data is captured on the rising edge |
| rst | input | 1 | Synchronous active-high clear of the data register |
| din | input | 8 | Eight data sources, bit k is source k |
| sel | input | 3 | Select code, binary |
| sel_hold | input | 1 | 0: select latch transparent, 1: latch holds |
| oe_lo_a | input | 1 | Output enable, active low |
| oe_lo_b | input | 1 | Output enable, active low |
| oe_hi | input | 1 | Output enable, active high |
| y | output | 1 | Selected stored bit, tristate |
| y_n | output | 1 | Inverse of `y`, tristate |
| drv_en | output | 1 | 1 when the outputs are driven |

## Verification
The assertions assume that the bench changes `sel` and `sel_hold` only away from the rising clock edge. Under that assumption the latched code seen at an edge is stable, and so is its history. The assertions also assume that the select latch has been loaded before the outputs are compared. The bench therefore drives every input on the falling edge or shortly after it. It opens the latch with a known code before the first output comparison. It tests high impedance only through `drv_en` and never by sampling a resolved Z.

// File: rtl/octsel_pkg.sv
package octsel_pkg;

    localparam int unsigned SRC_COUNT = 8;
    localparam int unsigned CODE_W    = $clog2(SRC_COUNT);

    // Output-enable group: two active-low enables and one active-high enable
    typedef struct packed {
        logic lo_a;
        logic lo_b;
        logic hi;
    } oe_grp_t;

    function automatic logic drive_ok(input oe_grp_t g);
        return (!g.lo_a) && (!g.lo_b) && g.hi;
    endfunction

endpackage

// File: rtl/octsel_dreg.sv
module octsel_dreg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    // One flip-flop per source, with synchronous clear
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= d[i];
        end
    end

    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d)));

    a_r2_clear: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/octsel_slatch.sv
module octsel_slatch #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] code_q
);

    // Transparent while hold is low
    always_latch begin
        if (!hold) code_q <= code_in;
    end

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold)) |-> $stable(code_q));

endmodule

// File: rtl/octsel_outdrv.sv
module octsel_outdrv
    import octsel_pkg::*;
#(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] data_q,
    input  logic [W-1:0] code_q,
    input  oe_grp_t      oe,
    output logic         y,
    output logic         y_n,
    output logic         en
);

    logic picked;

    always_comb picked = data_q[code_q];
    always_comb en     = drive_ok(oe);

    assign y   = en ? picked  : 1'bz;
    assign y_n = en ? ~picked : 1'bz;

endmodule

// File: rtl/octsel_reg.sv
module octsel_reg
    import octsel_pkg::*;
#(
    parameter int unsigned N_SRC = SRC_COUNT,
    localparam int unsigned SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] din,
    input  logic [SEL_W-1:0] sel,
    input  logic             sel_hold,
    input  logic             oe_lo_a,
    input  logic             oe_lo_b,
    input  logic             oe_hi,
    output logic             y,
    output logic             y_n,
    output logic             drv_en
);

    logic [N_SRC-1:0] data_q;
    logic [SEL_W-1:0] code_q;
    oe_grp_t          oe;

    always_comb oe = '{lo_a: oe_lo_a, lo_b: oe_lo_b, hi: oe_hi};

    octsel_dreg #(.N(N_SRC)) u_dreg (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (data_q)
    );

    octsel_slatch #(.W(SEL_W)) u_slatch (
        .clk     (clk),
        .rst     (rst),
        .hold    (sel_hold),
        .code_in (sel),
        .code_q  (code_q)
    );

    octsel_outdrv #(.N(N_SRC)) u_out (
        .data_q (data_q),
        .code_q (code_q),
        .oe     (oe),
        .y      (y),
        .y_n    (y_n),
        .en     (drv_en)
    );

    a_r5_select: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (y == data_q[code_q]));

    a_r6_complement: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (y != y_n));

    a_r7_enable: assert property (@(posedge clk) disable iff (rst)
        (!oe_lo_a && !oe_lo_b && oe_hi) |-> drv_en);

    a_r7_disable: assert property (@(posedge clk) disable iff (rst)
        (oe_lo_a || oe_lo_b || !oe_hi) |-> !drv_en);

endmodule

// File: tb/octsel_reg_test.sv
module octsel_reg_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = '0;
    logic [2:0] sel = '0;
    logic       sel_hold = 1'b0;
    logic       oe_lo_a = 1'b0;
    logic       oe_lo_b = 1'b0;
    logic       oe_hi = 1'b1;
    logic       y, y_n, drv_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // {data, code, expected y}
    localparam logic [11:0] VEC [10] = '{
        {8'hA5, 3'd0, 1'b1},
        {8'hA5, 3'd1, 1'b0},
        {8'hA5, 3'd2, 1'b1},
        {8'hA5, 3'd6, 1'b0},
        {8'h01, 3'd0, 1'b1},
        {8'h80, 3'd7, 1'b1},
        {8'h80, 3'd0, 1'b0},
        {8'h3C, 3'd5, 1'b1},
        {8'hFE, 3'd0, 1'b0},
        {8'h7F, 3'd7, 1'b0}
    };

    octsel_reg uut (
        .clk(clk), .rst(rst), .din(din), .sel(sel), .sel_hold(sel_hold),
        .oe_lo_a(oe_lo_a), .oe_lo_b(oe_lo_b), .oe_hi(oe_hi),
        .y(y), .y_n(y_n), .drv_en(drv_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_y(input string req, input logic exp);
        check(req, drv_en, 1'b1);
        check(req, y, exp);
        check({req, " complement"}, y_n, ~exp);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2: reset clears stored data even with all ones on din
        @(negedge clk);
        din = 8'hFF; sel = 3'd3; sel_hold = 1'b0;
        @(negedge clk);
        check_y("R2 reset clear code3", 1'b0);
        sel = 3'd7; #1;
        check_y("R2 reset clear code7", 1'b0);
        rst = 1'b0;

        // R5 / R1 / R6: vector table
        foreach (VEC[i]) begin
            @(negedge clk);
            din = VEC[i][11:4];
            sel = VEC[i][3:1];
            @(negedge clk);
            check_y("R5 table", VEC[i][0]);
        end

        // R1: data changes without a clock edge do not reach y
        @(negedge clk);
        din = 8'hA5; sel = 3'd0;
        @(negedge clk);
        check_y("R1 loaded", 1'b1);
        din = 8'h00; #1;
        check_y("R1 no edge", 1'b1);
        @(negedge clk);
        check_y("R1 after edge", 1'b0);
        din = 8'hA5;
        @(negedge clk);

        // R3: transparent select, no clock needed
        sel = 3'd1; #1;
        check_y("R3 transparent code1", 1'b0);
        sel = 3'd2; #1;
        check_y("R3 transparent code2", 1'b1);

        // R4: hold keeps the code
        sel_hold = 1'b1; #1;
        sel = 3'd1; #1;
        check_y("R4 hold ignores sel", 1'b1);
        @(negedge clk);
        check_y("R4 hold across edge", 1'b1);

        // R7: all eight enable combinations
        for (int k = 0; k < 8; k++) begin
            {oe_lo_a, oe_lo_b, oe_hi} = 3'(k); #1;
            check("R7 drv_en", drv_en, (k == 1) ? 1'b1 : 1'b0);
        end

        // R8: disabling outputs keeps stored data and code
        {oe_lo_a, oe_lo_b, oe_hi} = 3'b110;
        @(negedge clk);
        @(negedge clk);
        check("R8 disabled", drv_en, 1'b0);
        {oe_lo_a, oe_lo_b, oe_hi} = 3'b001; #1;
        check_y("R8 re-enabled", 1'b1);
        sel_hold = 1'b0; #1;
        check_y("R3 reopen latch code1", 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule